// File: doc/BRIEF.md
# Correlating Two-Level Branch Predictor

This block guesses the direction of conditional branches. It keeps a short global record of the most recent resolved branch outcomes. It also keeps a table of small saturating counters. Each table row is chosen by low-order bits of the branch address. The recorded history then picks one counter within that row, so a row holds one counter for each possible history pattern. The same branch can therefore learn a different direction for each recent path. This lets it follow alternating or path-dependent behaviour that a single counter per address cannot.

The fetch side presents a branch address on the lookup port and gets a taken or not-taken guess back in the same cycle. When the branch resolves, the execute side presents its address and real outcome on the training port. The counter chosen by that address and the current history moves one step towards the outcome. The outcome is then shifted into the history. With a history length of zero, the block reduces to a plain per-address table of counters.

Top module: `corr_predictor`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value (1 for 2-bit counters) and the history is zero, so every address predicts not taken.
- R2: `pred_taken` is 1 exactly when the counter selected for `pred_pc` has its most significant bit set (value 2 or 3 for 2-bit counters), and it is valid in the same cycle as `pred_pc`.
- R3: The table row is `pc[PC_LSB +: IDX_BITS]` (bits 5:2 by default); addresses that agree in those bits share a row, and addresses that differ in them train independently.
- R4: Within a row, the history value h selects counter h, so one address keeps a separate counter for each of the 2^HIST_LEN history patterns and can learn an alternating taken/not-taken sequence.
- R5: An update with `upd_taken`=1 increments the selected counter and one with `upd_taken`=0 decrements it, saturating at 0 and at the all-ones value (3).
- R6: An update changes only the counter selected by `upd_pc` and the current history; every other counter keeps its value.
- R7: The history shifts left and takes `upd_taken` into bit 0 only in a cycle with `upd_valid`=1; without an update, history and counters hold, so predictions for a given address do not change.
- R8: A counter in a strong state (0 or 3) needs two consecutive opposite outcomes before its prediction flips.
- R9: When a lookup and an update occur in the same cycle, the lookup returns the value held before the update.
- R10: With `HIST_LEN`=0 the block is a plain per-address table: the prediction for an address depends only on its own row's single counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pred_pc | input | ADDR_W | Address of the branch being looked up |
| pred_taken | output | 1 | Guess for `pred_pc`: 1 taken, 0 not taken |
| upd_valid | input | 1 | A resolved branch is presented for training this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch: 1 taken |

## Verification
The hardest situation to reach is training one counter repeatedly. Every update also moves the history, and so moves the column that the next update selects. The stimulus therefore uses runs of equal outcomes that pin the history to all-ones or all-zeros, so that saturation and the two-miss rule hit the same counter. Alternating sequences then walk two columns of one row, so the correlating instance learns the pattern while the history-free instance, fed the same traffic, keeps mispredicting. Aliased addresses and a lookup that coincides with an update at the same address complete the stimulus.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;

  // one saturating step of a counter up to 8 bits wide
  function automatic logic [7:0] sat_step(input logic [7:0] cur,
                                          input logic       up,
                                          input logic [7:0] top);
    logic [7:0] res;
    if (up) res = (cur == top)  ? cur : cur + 8'd1;
    else    res = (cur == 8'd0) ? cur : cur - 8'd1;
    return res;
  endfunction

endpackage

// File: rtl/corr_bp_history.sv
module corr_bp_history #(
  parameter int HIST_LEN = 2,
  localparam int HW = (HIST_LEN > 0) ? HIST_LEN : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          shift_bit,
  output logic [HW-1:0] hist_o
);

  generate
    if (HIST_LEN == 0) begin : g_none
      logic unused_in;
      assign unused_in = shift_en ^ shift_bit ^ clk ^ rst_n;
      assign hist_o    = '0;
    end else begin : g_shift
      logic [HW-1:0] hist_q;
      logic [HW-1:0] hist_d;

      always_comb begin
        hist_d = hist_q;
        if (shift_en) hist_d = HW'({hist_q, shift_bit});
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
      end

      assign hist_o = hist_q;
    end
  endgenerate

endmodule

// File: rtl/corr_bp_index.sv
module corr_bp_index #(
  parameter int ADDR_W   = 32,
  parameter int PC_LSB   = 2,
  parameter int IDX_BITS = 4,
  parameter int HIST_LEN = 2,
  localparam int HW    = (HIST_LEN > 0) ? HIST_LEN : 1,
  localparam int ENT_W = IDX_BITS + HIST_LEN
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [HW-1:0]     hist,
  output logic [ENT_W-1:0]  ent
);

  logic [IDX_BITS-1:0] row;
  assign row = pc[PC_LSB +: IDX_BITS];

  generate
    if (HIST_LEN == 0) begin : g_flat
      logic unused_h;
      assign unused_h = ^hist;
      assign ent      = row;
    end else begin : g_corr
      assign ent = {row, hist};
    end
  endgenerate

endmodule

// File: rtl/corr_bp_table.sv
module corr_bp_table #(
  parameter int IDX_W = 6,
  parameter int CTR_W = 2,
  localparam int ENTRIES = 1 << IDX_W,
  localparam logic [CTR_W-1:0] CTR_MAX = '1,
  localparam logic [CTR_W-1:0] CTR_RST = CTR_MAX >> 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [CTR_W-1:0]   rd_ctr,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_taken,
  output logic [CTR_W-1:0]   wr_cur,
  output logic [CTR_W-1:0]   wr_nxt,
  output logic [ENTRIES-1:0] wr_vec
);
  import corr_bp_pkg::*;

  logic [CTR_W-1:0] ctr_q [ENTRIES];

  assign rd_ctr = ctr_q[rd_idx];
  assign wr_cur = ctr_q[wr_idx];

  always_comb begin
    wr_nxt = CTR_W'(sat_step(8'(wr_cur), wr_taken, 8'(CTR_MAX)));
  end

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ctr
      logic             en;
      logic [CTR_W-1:0] d;

      assign en        = wr_en && (wr_idx == IDX_W'(e));
      assign wr_vec[e] = en;

      always_comb begin
        d = ctr_q[e];
        if (en) d = wr_nxt;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q[e] <= CTR_RST;
        else        ctr_q[e] <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/corr_predictor.sv
module corr_predictor #(
  parameter int ADDR_W   = 32,
  parameter int PC_LSB   = 2,
  parameter int IDX_BITS = 4,
  parameter int HIST_LEN = 2,
  parameter int CTR_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pred_pc,
  output logic              pred_taken,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken
);

  localparam int HW      = (HIST_LEN > 0) ? HIST_LEN : 1;
  localparam int ENT_W   = IDX_BITS + HIST_LEN;
  localparam int ENTRIES = 1 << ENT_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [HW-1:0]      hist;
  logic [ENT_W-1:0]   rd_ent;
  logic [ENT_W-1:0]   wr_ent;
  logic [CTR_W-1:0]   rd_ctr;
  logic [CTR_W-1:0]   wr_cur;
  logic [CTR_W-1:0]   wr_nxt;
  logic [ENTRIES-1:0] wr_vec;

  corr_bp_history #(.HIST_LEN(HIST_LEN)) u_hist (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .shift_en  (upd_valid),
    .shift_bit (upd_taken),
    .hist_o    (hist)
  );

  corr_bp_index #(
    .ADDR_W(ADDR_W), .PC_LSB(PC_LSB), .IDX_BITS(IDX_BITS), .HIST_LEN(HIST_LEN)
  ) u_rd_idx (
    .pc   (pred_pc),
    .hist (hist),
    .ent  (rd_ent)
  );

  corr_bp_index #(
    .ADDR_W(ADDR_W), .PC_LSB(PC_LSB), .IDX_BITS(IDX_BITS), .HIST_LEN(HIST_LEN)
  ) u_wr_idx (
    .pc   (upd_pc),
    .hist (hist),
    .ent  (wr_ent)
  );

  corr_bp_table #(.IDX_W(ENT_W), .CTR_W(CTR_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_idx   (rd_ent),
    .rd_ctr   (rd_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (wr_ent),
    .wr_taken (upd_taken),
    .wr_cur   (wr_cur),
    .wr_nxt   (wr_nxt),
    .wr_vec   (wr_vec)
  );

  assign pred_taken = rd_ctr[CTR_W-1];

endmodule

// File: rtl/corr_predictor_chk.sv
module corr_predictor_chk #(
  parameter int ADDR_W   = 32,
  parameter int HIST_LEN = 2,
  parameter int HW       = 2,
  parameter int ENTRIES  = 64,
  parameter int CTR_W    = 2
) (
  input logic               clk,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  pred_pc,
  input logic               pred_taken,
  input logic               upd_valid,
  input logic               upd_taken,
  input logic [HW-1:0]      hist,
  input logic [CTR_W-1:0]   wr_cur,
  input logic [CTR_W-1:0]   wr_nxt,
  input logic [ENTRIES-1:0] wr_vec
);
  localparam logic [CTR_W-1:0] CMAX = '1;

  generate
    if (HIST_LEN > 0) begin : g_hist_chk
      // R7: history takes the outcome in at bit 0 on an update
      a_r7_hist_shift: assert property (@(posedge clk) disable iff (!rst_ni)
        upd_valid |=> hist == HW'({$past(hist), $past(upd_taken)}));
    end
  endgenerate

  // R7: history holds without an update
  a_r7_hist_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !upd_valid |=> $stable(hist));

  // R7: no update and same address gives same prediction
  a_r7_pred_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !upd_valid |=> (!$stable(pred_pc) || $stable(pred_taken)));

  // R6: at most one counter written, exactly one on an update
  a_r6_one_write: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(wr_vec) && (!upd_valid || $countones(wr_vec) == 1));

  // R5: saturation at the bottom
  a_r5_sat_low: assert property (@(posedge clk) disable iff (!rst_ni)
    (upd_valid && !upd_taken && wr_cur == '0) |-> wr_nxt == '0);

  // R5: saturation at the top
  a_r5_sat_high: assert property (@(posedge clk) disable iff (!rst_ni)
    (upd_valid && upd_taken && wr_cur == CMAX) |-> wr_nxt == CMAX);

endmodule

bind corr_predictor corr_predictor_chk #(
  .ADDR_W(ADDR_W), .HIST_LEN(HIST_LEN), .HW(HW), .ENTRIES(ENTRIES), .CTR_W(CTR_W)
) u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .pred_pc    (pred_pc),
  .pred_taken (pred_taken),
  .upd_valid  (upd_valid),
  .upd_taken  (upd_taken),
  .hist       (hist),
  .wr_cur     (wr_cur),
  .wr_nxt     (wr_nxt),
  .wr_vec     (wr_vec)
);

// File: tb/corr_predictor_bench.sv
module corr_predictor_bench;

  localparam int ROWS = 16;
  localparam int COLS = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pred_pc;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_taken;
  logic        pred_main;
  logic        pred_flat;

  always #5 clk = ~clk;

  corr_predictor u_corr_predictor (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_main),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  corr_predictor #(.HIST_LEN(0)) u_flat (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_flat),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  typedef struct {
    bit    exp_main;
    bit    exp_flat;
    string tag;
  } item_t;

  item_t q[$];
  int    mdl [ROWS][COLS];
  int    fl  [ROWS];
  int    hist;
  int    checks = 0;
  int    fails  = 0;

  function automatic int row_of(input logic [31:0] pc);
    return int'((pc >> 2) & 32'hF);
  endfunction

  function automatic int sat(input int v, input bit up);
    if (up) return (v == 3) ? 3 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic step(input logic [31:0] ppc, input bit uv,
                      input logic [31:0] upc, input bit ut, input string tag);
    item_t it;
    @(negedge clk);
    pred_pc   = ppc;
    upd_valid = uv;
    upd_pc    = upc;
    upd_taken = ut;
    it.exp_main = mdl[row_of(ppc)][hist] >= 2;
    it.exp_flat = fl[row_of(ppc)] >= 2;
    it.tag      = tag;
    q.push_back(it);
    if (uv) begin
      mdl[row_of(upc)][hist] = sat(mdl[row_of(upc)][hist], ut);
      fl[row_of(upc)]        = sat(fl[row_of(upc)], ut);
      hist = ((hist << 1) | int'(ut)) & 3;
    end
  endtask

  task automatic look(input logic [31:0] ppc, input string tag);
    step(ppc, 1'b0, 32'h0, 1'b0, tag);
  endtask

  task automatic train(input logic [31:0] pc, input bit t, input string tag);
    step(pc, 1'b1, pc, t, tag);
  endtask

  // monitor: compares after the inputs of each cycle have settled
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (pred_main !== it.exp_main) begin
          fails++;
          $display("FAIL %s main: actual %0b expected %0b", it.tag, pred_main, it.exp_main);
        end
        checks++;
        if (pred_flat !== it.exp_flat) begin
          fails++;
          $display("FAIL %s flat: actual %0b expected %0b", it.tag, pred_flat, it.exp_flat);
        end
      end
    end
  end

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam logic [31:0] PA = 32'h0000_0044; // row 1
  localparam logic [31:0] PA_ALIAS = 32'h0000_0084; // row 1 too
  localparam logic [31:0] PC_ = 32'h0000_0088; // row 2
  localparam logic [31:0] PD = 32'h0000_0060; // row 8
  localparam logic [31:0] PE = 32'h0000_0054; // row 5

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      fl[r] = 1;
      for (int c = 0; c < COLS; c++) mdl[r][c] = 1;
    end
    hist      = 0;
    rst_n     = 1'b0;
    pred_pc   = '0;
    upd_valid = 1'b0;
    upd_pc    = '0;
    upd_taken = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: everything predicts not taken after reset
    look(32'h0, "R1");
    look(PA, "R1");
    look(32'h3C, "R1");

    // R5 R2: repeated taken outcomes drive history to 3 and saturate column 3
    for (int i = 0; i < 5; i++) train(PA, 1'b1, "R5");
    look(PA, "R2");

    // R8: one not-taken on a strong counter then re-establish history 3
    train(PA, 1'b0, "R8");
    train(PE, 1'b1, "R8");
    train(PE, 1'b1, "R8");
    look(PA, "R8");
    train(PA, 1'b0, "R8");
    train(PA, 1'b0, "R8");
    look(PA, "R8");

    // R3: aliasing address shares the row, other rows untouched
    look(PA_ALIAS, "R3");
    look(PC_, "R3");

    // R4 R10: alternating pattern learned by history columns only
    for (int i = 0; i < 10; i++) train(PC_, (i % 2) == 0, "R4");
    for (int i = 0; i < 4; i++) train(PC_, (i % 2) == 0, "R10");

    // R5: saturate low, one taken is not enough to flip
    for (int i = 0; i < 5; i++) train(PD, 1'b0, "R5");
    train(PD, 1'b1, "R5");
    look(PD, "R5");

    // R6: a row never trained still predicts not taken
    look(32'h0000_0070, "R6");

    // R9: lookup and update at the same address in one cycle
    train(PA, 1'b1, "R9");
    train(PA, 1'b1, "R9");
    train(PA, 1'b1, "R9");
    look(PA, "R9");

    // R7: no updates, predictions stable
    for (int i = 0; i < 3; i++) look(PA, "R7");
    look(PC_, "R7");
    look(PC_, "R7");

    @(negedge clk);
    upd_valid = 1'b0;
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule